// File: doc/BRIEF.md
# Exception Return Context Restorer

This block performs the data-side work of a return from an exception handler. When `start` is pulsed it looks at the saved-context link word and the call-depth control field. If any of three trap conditions holds, it raises the matching trap flags and finishes without touching memory or registers.

Otherwise it restores the interrupt-enable bit and the current priority from the link word. It then forms the frame address from the segment and offset fields of the link word. It reads the sixteen-word upper frame into the link, status and upper address and data registers, in a fixed order. Finally it writes the current free-list head into the first word of the released frame, making that frame the new head of the free list.

Field positions:
- Link word: previous priority in [31:24], previous interrupt enable in bit 23, upper/lower frame flag in bit 22, segment in [19:16], offset in [15:0].
- Interrupt control word: interrupt enable in bit 8, current priority in [7:0].
- Depth control input: enable in bit 7, depth field in [6:0].

The memory port issues one word access at a time. `mem_req` is held with a stable address and direction until `mem_ready` is seen high at a clock edge.

Top module: `ctx_return_unit`

## Requirements
- R1: A start with link bits [19:0] all zero raises `trap_underflow` for one cycle.
- R2: A start with link bit 22 equal to 0 raises `trap_type` for one cycle.
- R3: A start with depth-control bit 7 set raises `trap_nest` for one cycle when the depth count is non-zero. The count is zero when no set bit of the 7-bit field [6:0] has a clear bit directly above it. This covers 7'h7F, 7'h00, and a run of ones down from bit 6 followed by zeros.
- R4: When any trap is raised, the block makes no memory request and asserts no write enable. `done` pulses in the same cycle as the trap flags.
- R5: On a trap-free start, `icr_we` pulses once. `icr_wdata` carries bits [31:9] of `icr_i`, bit 8 equal to link bit 23, and bits [7:0] equal to link bits [31:24].
- R6: The frame address is {link[19:16], 6'b0, link[15:0], 6'b0}.
- R7: Sixteen reads are issued at frame address + 4*k, for k = 0 to 15. Word 0 is the new link, word 1 goes to status, words 2-3 go to A10-A11, words 4-7 to D8-D11, words 8-11 to A12-A15 and words 12-15 to D12-D15. Each register write is presented on `rf_idx`/`rf_wdata` (or `status_wdata`) one cycle after its read is accepted.
- R8: After the reads, exactly one write is issued to the frame address, carrying the `free_head_i` value latched at start.
- R9: At the end, `free_wdata` = {free_head[31:20], old link[19:0]} and `link_wdata` = word 0 of the frame. Both are presented with `free_we` and `link_we` in the cycle `done` pulses.
- R10: Out of reset, `busy`, `done`, `mem_req` and all flags are low. `busy` is high from the cycle after a trap-free start until the final write is accepted, and `done` is a one-cycle pulse. A `start` seen while busy is ignored.
- R11: While `mem_req` is high and `mem_ready` is low, `mem_addr`, `mem_we` and `mem_req` hold their values. Each access therefore takes wait+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an exception return |
| link_i | input | 32 | Current saved-context link word |
| depth_ctl_i | input | 8 | Depth check enable (bit 7) and depth field |
| free_head_i | input | 32 | Current free-context list head |
| icr_i | input | 32 | Current interrupt control word |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access accepted this cycle |
| a_we | output | 1 | Address register write strobe |
| d_we | output | 1 | Data register write strobe |
| rf_idx | output | 4 | Register number for a_we/d_we |
| rf_wdata | output | 32 | Register write data |
| status_we | output | 1 | Status register write strobe |
| status_wdata | output | 32 | Status register write data |
| link_we | output | 1 | Link register write strobe |
| link_wdata | output | 32 | New link word |
| free_we | output | 1 | Free-list head write strobe |
| free_wdata | output | 32 | New free-list head |
| icr_we | output | 1 | Interrupt control write strobe |
| icr_wdata | output | 32 | New interrupt control word |
| trap_underflow | output | 1 | Empty-link trap |
| trap_type | output | 1 | Wrong frame type trap |
| trap_nest | output | 1 | Call-depth trap |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished (one cycle) |

## Verification
The hold-while-waiting property assumes the memory answers each request eventually and never raises `mem_ready` without `mem_req`. The bench memory model only asserts ready for a request, after a fixed number of wait cycles chosen per scenario (0, 1 or 2). The properties also take `start` to be a pulse whose link and depth inputs are stable in that cycle. The bench drives every input on falling edges, and it changes the link input mid-run only to show that the latched value is the one used.

// File: rtl/ctxr_pkg.sv
package ctxr_pkg;
  localparam int WORD_W = 32;

  // link word field positions
  localparam int LNK_PRIO_HI = 31;
  localparam int LNK_PRIO_LO = 24;
  localparam int LNK_PIE     = 23;
  localparam int LNK_UPPER   = 22;
  localparam int LNK_SEG_HI  = 19;
  localparam int LNK_SEG_LO  = 16;
  localparam int LNK_OFF_HI  = 15;
  localparam int LNK_PTR_W   = 20;

  // interrupt control word positions
  localparam int ICR_IE      = 8;

  typedef enum logic [1:0] {
    DST_LINK,
    DST_STATUS,
    DST_AREG,
    DST_DREG
  } dst_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_FREE
  } state_e;
endpackage

// File: rtl/ctxr_trap_eval.sv
module ctxr_trap_eval #(
  parameter int DEPTH_W = 7,
  parameter int PTR_W   = 20
) (
  input  logic [PTR_W-1:0]   link_ptr,
  input  logic               link_upper,
  input  logic               depth_en,
  input  logic [DEPTH_W-1:0] depth,
  output logic               underflow,
  output logic               type_err,
  output logic               nest
);
  logic count_zero;

  // The count sits below the highest clear bit. It is zero exactly when
  // no set bit has a clear bit directly above it.
  always_comb begin
    count_zero = 1'b1;
    for (int i = 0; i < DEPTH_W - 1; i++) begin
      if (depth[i] && !depth[i+1]) count_zero = 1'b0;
    end
  end

  assign underflow = (link_ptr == '0);
  assign type_err  = !link_upper;
  assign nest      = depth_en && !count_zero;
endmodule

// File: rtl/ctxr_word_router.sv
module ctxr_word_router
  import ctxr_pkg::*;
(
  input  logic [3:0] widx,
  output dst_e       dst,
  output logic [3:0] reg_num
);
  // frame order: link, status, A10, A11, D8-D11, A12-A15, D12-D15
  always_comb begin
    unique case (widx[3:2])
      2'd0: begin
        if (!widx[1]) begin
          dst     = widx[0] ? DST_STATUS : DST_LINK;
          reg_num = 4'd0;
        end else begin
          dst     = DST_AREG;
          reg_num = {3'b101, widx[0]};
        end
      end
      2'd1: begin
        dst     = DST_DREG;
        reg_num = {2'b10, widx[1:0]};
      end
      2'd2: begin
        dst     = DST_AREG;
        reg_num = {2'b11, widx[1:0]};
      end
      default: begin
        dst     = DST_DREG;
        reg_num = {2'b11, widx[1:0]};
      end
    endcase
  end
endmodule

// File: rtl/ctx_return_unit.sv
module ctx_return_unit
  import ctxr_pkg::*;
#(
  parameter int FRAME_WORDS = 16,
  parameter int DEPTH_W     = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [31:0]       link_i,
  input  logic [DEPTH_W:0]  depth_ctl_i,
  input  logic [31:0]       free_head_i,
  input  logic [31:0]       icr_i,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ready,
  output logic              a_we,
  output logic              d_we,
  output logic [3:0]        rf_idx,
  output logic [31:0]       rf_wdata,
  output logic              status_we,
  output logic [31:0]       status_wdata,
  output logic              link_we,
  output logic [31:0]       link_wdata,
  output logic              free_we,
  output logic [31:0]       free_wdata,
  output logic              icr_we,
  output logic [31:0]       icr_wdata,
  output logic              trap_underflow,
  output logic              trap_type,
  output logic              trap_nest,
  output logic              busy,
  output logic              done
);
  localparam int IDX_W  = $clog2(FRAME_WORDS);
  localparam int LAST   = FRAME_WORDS - 1;
  localparam int HEAD_W = WORD_W - LNK_PTR_W;

  state_e              state;
  logic [IDX_W-1:0]    widx;
  logic [31:0]         ea_q;
  logic [LNK_PTR_W-1:0] old_ptr_q;
  logic [31:0]         head_q;
  logic [31:0]         new_link_q;
  logic [31:0]         ea_c;
  logic                t_uf, t_ty, t_ns;
  dst_e                dst;
  logic [3:0]          reg_num;
  logic                unused_bits;

  assign unused_bits = ^{link_i[21:20], icr_i[ICR_IE:0]};

  ctxr_trap_eval #(.DEPTH_W(DEPTH_W), .PTR_W(LNK_PTR_W)) trap_i (
    .link_ptr   (link_i[LNK_PTR_W-1:0]),
    .link_upper (link_i[LNK_UPPER]),
    .depth_en   (depth_ctl_i[DEPTH_W]),
    .depth      (depth_ctl_i[DEPTH_W-1:0]),
    .underflow  (t_uf),
    .type_err   (t_ty),
    .nest       (t_ns)
  );

  ctxr_word_router route_i (
    .widx    (widx[3:0]),
    .dst     (dst),
    .reg_num (reg_num)
  );

  // 64-byte aligned frame: segment, 6 zeros, offset, 6 zeros
  assign ea_c = {link_i[LNK_SEG_HI:LNK_SEG_LO], 6'b0, link_i[LNK_OFF_HI:0], 6'b0};

  assign busy      = (state != ST_IDLE);
  assign mem_req   = (state != ST_IDLE);
  assign mem_we    = (state == ST_FREE);
  assign mem_addr  = (state == ST_READ) ?
                     (ea_q + {{(30-IDX_W){1'b0}}, widx, 2'b00}) : ea_q;
  assign mem_wdata = head_q;
  assign status_wdata = rf_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      widx           <= '0;
      ea_q           <= '0;
      old_ptr_q      <= '0;
      head_q         <= '0;
      new_link_q     <= '0;
      a_we           <= 1'b0;
      d_we           <= 1'b0;
      rf_idx         <= '0;
      rf_wdata       <= '0;
      status_we      <= 1'b0;
      link_we        <= 1'b0;
      link_wdata     <= '0;
      free_we        <= 1'b0;
      free_wdata     <= '0;
      icr_we         <= 1'b0;
      icr_wdata      <= '0;
      trap_underflow <= 1'b0;
      trap_type      <= 1'b0;
      trap_nest      <= 1'b0;
      done           <= 1'b0;
    end else begin
      a_we           <= 1'b0;
      d_we           <= 1'b0;
      status_we      <= 1'b0;
      link_we        <= 1'b0;
      free_we        <= 1'b0;
      icr_we         <= 1'b0;
      trap_underflow <= 1'b0;
      trap_type      <= 1'b0;
      trap_nest      <= 1'b0;
      done           <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            if (t_uf || t_ty || t_ns) begin
              trap_underflow <= t_uf;
              trap_type      <= t_ty;
              trap_nest      <= t_ns;
              done           <= 1'b1;
            end else begin
              ea_q      <= ea_c;
              old_ptr_q <= link_i[LNK_PTR_W-1:0];
              head_q    <= free_head_i;
              icr_we    <= 1'b1;
              icr_wdata <= {icr_i[31:ICR_IE+1], link_i[LNK_PIE],
                            link_i[LNK_PRIO_HI:LNK_PRIO_LO]};
              widx      <= '0;
              state     <= ST_READ;
            end
          end
        end
        ST_READ: begin
          if (mem_ready) begin
            rf_wdata <= mem_rdata;
            rf_idx   <= reg_num;
            unique case (dst)
              DST_LINK:   new_link_q <= mem_rdata;
              DST_STATUS: status_we  <= 1'b1;
              DST_AREG:   a_we       <= 1'b1;
              default:    d_we       <= 1'b1;
            endcase
            if (widx == IDX_W'(LAST)) state <= ST_FREE;
            else                      widx  <= widx + 1'b1;
          end
        end
        default: begin
          if (mem_ready) begin
            free_we    <= 1'b1;
            free_wdata <= {head_q[31:LNK_PTR_W], old_ptr_q};
            link_we    <= 1'b1;
            link_wdata <= new_link_q;
            done       <= 1'b1;
            state      <= ST_IDLE;
          end
        end
      endcase
    end
  end

  // R11: a pending access holds its address and direction
  a_r11_hold_pending: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R4: a trap outcome comes with no access and no write strobe
  a_r4_quiet_on_trap: assert property (@(posedge clk) disable iff (rst)
    (trap_underflow || trap_type || trap_nest) |->
      (done && !mem_req && !a_we && !d_we && !status_we && !link_we && !free_we && !icr_we));

  // R10: done is a single-cycle pulse and never overlaps busy
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R8: the release write goes to a 64-byte aligned frame start
  a_r8_free_aligned: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_addr[5:0] == 6'd0));

  // R7: at most one register destination per cycle
  a_r7_one_dest: assert property (@(posedge clk) disable iff (rst)
    $onehot0({a_we, d_we, status_we, icr_we}));

  // R9: link and free head are updated together, at completion
  a_r9_link_with_free: assert property (@(posedge clk) disable iff (rst)
    free_we |-> (link_we && done));
endmodule

// File: tb/ctx_return_unit_tb.sv
module ctx_return_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] link_i = '0;
  logic [7:0]  depth_ctl_i = '0;
  logic [31:0] free_head_i = '0;
  logic [31:0] icr_i = '0;
  logic        mem_req, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        a_we, d_we, status_we, link_we, free_we, icr_we;
  logic [3:0]  rf_idx;
  logic [31:0] rf_wdata, status_wdata, link_wdata, free_wdata, icr_wdata;
  logic        trap_underflow, trap_type, trap_nest, busy, done;

  int errors = 0;
  int checks = 0;
  int waits = 0;
  logic [3:0] wcnt = '0;

  always #5 clk = ~clk;

  ctx_return_unit dut_i (
    .clk(clk), .rst(rst), .start(start), .link_i(link_i),
    .depth_ctl_i(depth_ctl_i), .free_head_i(free_head_i), .icr_i(icr_i),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .a_we(a_we), .d_we(d_we), .rf_idx(rf_idx), .rf_wdata(rf_wdata),
    .status_we(status_we), .status_wdata(status_wdata),
    .link_we(link_we), .link_wdata(link_wdata),
    .free_we(free_we), .free_wdata(free_wdata),
    .icr_we(icr_we), .icr_wdata(icr_wdata),
    .trap_underflow(trap_underflow), .trap_type(trap_type),
    .trap_nest(trap_nest), .busy(busy), .done(done)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return a ^ 32'hC3C3_0000 ^ {a[7:0], 24'h0};
  endfunction

  // memory model: content is a function of address, fixed wait states
  assign mem_rdata = pat(mem_addr);
  assign mem_ready = mem_req && (int'(wcnt) >= waits);
  always @(posedge clk) begin
    if (mem_req && !mem_ready) wcnt <= wcnt + 1'b1;
    else                       wcnt <= '0;
  end

  // port monitors, sampled on the falling edge
  logic [31:0] rd_addr [32];
  logic [31:0] areg [16];
  logic [31:0] dreg [16];
  int rd_n, wr_n, a_n, d_n, st_n, lk_n, fr_n, ic_n, done_n, busy_n;
  logic [31:0] wr_addr, wr_data, st_cap, lk_cap, fr_cap, ic_cap;
  logic uf_cap, ty_cap, ns_cap, done_with_free;

  task automatic clear_log();
    rd_n = 0; wr_n = 0; a_n = 0; d_n = 0; st_n = 0; lk_n = 0; fr_n = 0;
    ic_n = 0; done_n = 0; busy_n = 0;
    uf_cap = 0; ty_cap = 0; ns_cap = 0; done_with_free = 0;
    wr_addr = '0; wr_data = '0; st_cap = '0; lk_cap = '0; fr_cap = '0; ic_cap = '0;
    for (int k = 0; k < 16; k++) begin areg[k] = '0; dreg[k] = '0; end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (mem_req && mem_ready && !mem_we) begin
        if (rd_n < 32) rd_addr[rd_n] = mem_addr;
        rd_n++;
      end
      if (mem_req && mem_ready && mem_we) begin
        wr_n++; wr_addr = mem_addr; wr_data = mem_wdata;
      end
      if (a_we) begin areg[rf_idx] = rf_wdata; a_n++; end
      if (d_we) begin dreg[rf_idx] = rf_wdata; d_n++; end
      if (status_we) begin st_cap = status_wdata; st_n++; end
      if (link_we) begin lk_cap = link_wdata; lk_n++; end
      if (free_we) begin fr_cap = free_wdata; fr_n++; end
      if (icr_we) begin ic_cap = icr_wdata; ic_n++; end
      if (done) begin
        done_n++;
        uf_cap = trap_underflow; ty_cap = trap_type; ns_cap = trap_nest;
        done_with_free = free_we;
      end
      if (busy) busy_n++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_case(input string name, input logic [31:0] link,
                          input logic [7:0] dctl, input logic [31:0] head,
                          input logic [31:0] icr, input int nwait,
                          input logic exp_uf, input logic exp_ty,
                          input logic exp_ns, input logic restart);
    logic [31:0] ea;
    logic trap;
    int guard;
    trap = exp_uf || exp_ty || exp_ns;
    ea = {link[19:16], 6'b0, link[15:0], 6'b0};
    waits = nwait;
    clear_log();
    @(negedge clk);
    link_i = link; depth_ctl_i = dctl; free_head_i = head; icr_i = icr;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (restart) begin
      repeat (3) @(negedge clk);
      link_i = 32'h0000_0000;   // would trap if taken
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (done_n == 0 && guard < 500) begin @(negedge clk); guard++; end
    repeat (3) @(negedge clk);
    if (guard >= 500) chk({name, " R10 watchdog"}, 32'd0, 32'd1);
    $display("case %s", name);
    chk("R1 underflow flag", 32'(uf_cap), 32'(exp_uf));
    chk("R2 type flag", 32'(ty_cap), 32'(exp_ty));
    chk("R3 nest flag", 32'(ns_cap), 32'(exp_ns));
    chk("R10 one done pulse", 32'(done_n), 32'd1);
    if (trap) begin
      chk("R4 no memory access", 32'(rd_n + wr_n), 32'd0);
      chk("R4 no writes", 32'(a_n + d_n + st_n + lk_n + fr_n + ic_n), 32'd0);
      chk("R4 not busy", 32'(busy_n), 32'd0);
    end else begin
      chk("R5 icr strobes", 32'(ic_n), 32'd1);
      chk("R5 icr value", ic_cap, {icr[31:9], link[23], link[31:24]});
      chk("R7 read count", 32'(rd_n), 32'd16);
      chk("R6 frame address", rd_addr[0], ea);
      for (int k = 1; k < 16; k++) chk("R7 read order", rd_addr[k], ea + 32'(4 * k));
      chk("R7 status", st_cap, pat(ea + 32'd4));
      chk("R7 A10", areg[10], pat(ea + 32'd8));
      chk("R7 A11", areg[11], pat(ea + 32'd12));
      for (int j = 0; j < 4; j++) begin
        chk("R7 D8-D11", dreg[8 + j], pat(ea + 32'(16 + 4 * j)));
        chk("R7 A12-A15", areg[12 + j], pat(ea + 32'(32 + 4 * j)));
        chk("R7 D12-D15", dreg[12 + j], pat(ea + 32'(48 + 4 * j)));
      end
      chk("R7 register write counts", 32'(a_n * 100 + d_n * 10 + st_n), 32'(6 * 100 + 8 * 10 + 1));
      chk("R8 one write", 32'(wr_n), 32'd1);
      chk("R8 write address", wr_addr, ea);
      chk("R8 write data", wr_data, head);
      chk("R9 free head", fr_cap, {head[31:20], link[19:0]});
      chk("R9 new link", lk_cap, pat(ea));
      chk("R9 updates with done", 32'(done_with_free), 32'd1);
      chk("R11 busy cycles", 32'(busy_n), 32'(17 * (nwait + 1)));
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R10 reset busy", 32'(busy), 32'd0);
    chk("R10 reset done", 32'(done), 32'd0);
    chk("R10 reset mem_req", 32'(mem_req), 32'd0);
    chk("R10 reset flags", 32'({trap_underflow, trap_type, trap_nest}), 32'd0);
  endtask

  task automatic t_plain();
    run_case("plain", {8'h5C, 1'b1, 1'b1, 2'b00, 4'h3, 16'h0012}, 8'h00,
             32'hABC0_0007, 32'h1234_5FFF, 0, 0, 0, 0, 0);
  endtask

  task automatic t_waits_depth_all_ones();
    // R3: enabled check, field 7'h7F counts as zero; restart ignored (R10)
    run_case("waits", {8'hA1, 1'b0, 1'b1, 2'b11, 4'hF, 16'hFFFF}, {1'b1, 7'h7F},
             32'h0F0F_1234, 32'hFFFF_FE00, 2, 0, 0, 0, 1);
  endtask

  task automatic t_depth_prefix();
    run_case("prefix", {8'h07, 1'b1, 1'b1, 2'b01, 4'h1, 16'h0200}, {1'b1, 7'b1100000},
             32'h5555_AAAA, 32'h0000_0000, 1, 0, 0, 0, 0);
  endtask

  task automatic t_depth_disabled();
    run_case("nocheck", {8'h80, 1'b0, 1'b1, 2'b00, 4'h8, 16'h0001}, {1'b0, 7'b0000101},
             32'h0000_0000, 32'h8000_0100, 0, 0, 0, 0, 0);
  endtask

  task automatic t_underflow();
    run_case("underflow", {8'h11, 1'b1, 1'b1, 2'b00, 20'h0}, 8'h00,
             32'h1, 32'h2, 0, 1, 0, 0, 0);
  endtask

  task automatic t_type();
    run_case("type", {8'h11, 1'b1, 1'b0, 2'b00, 20'h00040}, 8'h00,
             32'h1, 32'h2, 0, 0, 1, 0, 0);
  endtask

  task automatic t_nest();
    run_case("nest_a", {8'h22, 1'b1, 1'b1, 2'b00, 20'h00041}, {1'b1, 7'b1100001},
             32'h1, 32'h2, 0, 0, 0, 1, 0);
    run_case("nest_b", {8'h22, 1'b1, 1'b1, 2'b00, 20'h00041}, {1'b1, 7'b0000001},
             32'h1, 32'h2, 0, 0, 0, 1, 0);
  endtask

  task automatic t_all_traps();
    run_case("combined", 32'h0, {1'b1, 7'b0100000},
             32'h1, 32'h2, 0, 1, 1, 1, 0);
  endtask

  initial begin
    clear_log();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_plain();
    t_waits_depth_all_ones();
    t_depth_prefix();
    t_depth_disabled();
    t_underflow();
    t_type();
    t_nest();
    t_all_traps();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R10 watchdog expired: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule